// File: doc/BRIEF.md
# SMBus Host Command and Status Register Front End

This block is the byte-wide register face of an SMBus host controller. A processor fills in a slave address byte, a command byte and two data bytes, then writes a control byte. That control byte selects the transaction type and carries a start bit. The block hands the transaction to an external wire engine through a single-cycle request. It holds the operands stable while the engine works, then records the outcome in a status register. The engine signals completion with a done pulse and optional error flags, and the block turns that outcome into status bits and an interrupt line. Status flags are cleared by writing 1 to them.

A kill bit in the control byte aborts a running transaction. The block then pulses an abort strobe to the engine, drops busy and marks the transaction as failed. The sequencer has four states. IDLE goes to ISSUE on an accepted start. ISSUE goes to WAIT after its single request cycle, or to ABORT if a kill arrives. WAIT goes back to IDLE on engine done, or to ABORT on a kill. ABORT always returns to IDLE one cycle later.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0x00, irq is low and neither eng_req nor eng_abort is asserted.
- R2: A control write with bit 6 set and bit 1 clear while idle sets status bit 0 (busy) from the next cycle. It also raises eng_req for exactly one cycle, with eng_kind taken from control bits 4:2 (quick 0, byte 1, byte data 2, word 3, process call 4, block 5, raw block 6) and eng_pec taken from control bit 7.
- R3: The register offsets are: status 0, control 2, command 3, address 4, data0 5, data1 6. Every other offset reads 0x00. The address byte (slave address in bits 7:1, read flag in bit 0), the command byte and both data bytes appear unchanged on eng_addr, eng_cmd, eng_d0 and eng_d1.
- R4: When eng_done arrives in WAIT without an error, busy clears and status bit 1 (complete) sets on the same clock edge.
- R5: When eng_done arrives with eng_err_dev, status bit 2 sets. With eng_err_bus, status bit 3 sets. In either case bit 1 stays clear.
- R6: On an error-free completion with address bit 0 set, type byte (1) or byte data (2) loads data0 from eng_res0. Type word (3) loads data0 from eng_res0 (low byte) and data1 from eng_res1 (high byte).
- R7: A control write with bit 1 set while busy moves the block to ABORT. In ABORT, eng_abort is high for one cycle and eng_done is ignored. The block then becomes idle with status bit 4 (failed) set. A start written together with bit 1 while idle is not launched.
- R8: Writing 1 to any of status bits 7:1 clears that bit, and writing 0 leaves it unchanged. Status bit 0 cannot be written. When a set event and a clear land in the same cycle, the set wins.
- R9: While busy, a start is ignored. Writes to the command, address and data registers are ignored, and control writes change only the kill bit.
- R10: A status read taken while bit 6 (in use) is clear returns it clear, and the bit sets after that read.
- R11: A pulse on eng_byte_done sets status bit 7, and a pulse on alert_evt sets status bit 5.
- R12: irq is high exactly when any of status bits 4:1 is set. Bits 7, 6 and 5 do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives status side effects) |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| eng_req | output | 1 | One-cycle transaction request to the engine |
| eng_abort | output | 1 | One-cycle abort strobe to the engine |
| eng_kind | output | 3 | Transaction type |
| eng_pec | output | 1 | Packet error checking enable |
| eng_addr | output | DATA_W | Address byte |
| eng_cmd | output | DATA_W | Command byte |
| eng_d0 | output | DATA_W | Data byte 0 |
| eng_d1 | output | DATA_W | Data byte 1 |
| eng_done | input | 1 | Engine completion pulse |
| eng_err_dev | input | 1 | No-response error, valid with eng_done |
| eng_err_bus | input | 1 | Lost-arbitration error, valid with eng_done |
| eng_res0 | input | DATA_W | Read result low byte |
| eng_res1 | input | DATA_W | Read result high byte |
| eng_byte_done | input | 1 | Per-byte progress pulse |
| alert_evt | input | 1 | Alert event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a kill that races other traffic. The bench writes the kill bit while the sequencer waits and drives eng_done in the ABORT cycle itself. It then confirms that the completion is dropped and only the failed flag appears. The bench also writes a start and operand bytes in the middle of a transaction, then reads the registers back to show they did not move. A behavioural model compares eng_req, eng_abort and irq against the design on every clock.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_ABORT = 2'd3
    } seq_state_t;

    // register offsets (software decodes these)
    localparam int OFS_STAT = 0;
    localparam int OFS_CTRL = 2;
    localparam int OFS_CMD  = 3;
    localparam int OFS_ADDR = 4;
    localparam int OFS_D0   = 5;
    localparam int OFS_D1   = 6;

    // status bit positions
    localparam int B_BYTE  = 7;
    localparam int B_INUSE = 6;
    localparam int B_ALERT = 5;
    localparam int B_FAIL  = 4;
    localparam int B_BUS   = 3;
    localparam int B_DEV   = 2;
    localparam int B_INTR  = 1;

    // control bit positions
    localparam int C_PEC   = 7;
    localparam int C_START = 6;
    localparam int C_KILL  = 1;
    localparam int KIND_LO = 2;
    localparam int KIND_W  = 3;

    localparam logic [KIND_W-1:0] K_BYTE  = 3'd1;
    localparam logic [KIND_W-1:0] K_BDATA = 3'd2;
    localparam logic [KIND_W-1:0] K_WORD  = 3'd3;

endpackage

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic kill_req,
    input  logic eng_done,
    input  logic eng_err_dev,
    input  logic eng_err_bus,
    output logic busy,
    output logic eng_req,
    output logic eng_abort,
    output logic ev_ok,
    output logic ev_dev,
    output logic ev_bus,
    output logic ev_fail
);

    seq_state_t state_q, state_d;
    logic       finish;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_req) state_d = S_ISSUE;
            S_ISSUE: state_d = kill_req ? S_ABORT : S_WAIT;
            S_WAIT: begin
                if (kill_req)      state_d = S_ABORT;
                else if (eng_done) state_d = S_IDLE;
            end
            S_ABORT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        eng_req   = (state_q == S_ISSUE);
        eng_abort = (state_q == S_ABORT);
        finish    = (state_q == S_WAIT) && !kill_req && eng_done;
        ev_dev    = finish && eng_err_dev;
        ev_bus    = finish && eng_err_bus;
        ev_ok     = finish && !eng_err_dev && !eng_err_bus;
        ev_fail   = (state_q == S_ABORT);
    end

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);
    p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> eng_req);
    p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !busy);
    p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !eng_req);
    p_events_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_ok, ev_fail, ev_dev | ev_bus}));

endmodule

// File: rtl/smbh_status.sv
module smbh_status
    import smbh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [DATA_W-1:1] wmask,
    input  logic              rd_en,
    input  logic              ev_ok,
    input  logic              ev_dev,
    input  logic              ev_bus,
    input  logic              ev_fail,
    input  logic              byte_evt,
    input  logic              alert_evt,
    output logic [DATA_W-1:0] stat,
    output logic              irq
);

    logic [DATA_W-1:1] flags_q, flags_d, set_v, clr_v;

    always_comb begin
        set_v          = '0;
        set_v[B_BYTE]  = byte_evt;
        set_v[B_INUSE] = rd_en && !flags_q[B_INUSE];
        set_v[B_ALERT] = alert_evt;
        set_v[B_FAIL]  = ev_fail;
        set_v[B_BUS]   = ev_bus;
        set_v[B_DEV]   = ev_dev;
        set_v[B_INTR]  = ev_ok;
        clr_v          = wr_en ? wmask : '0;
        flags_d        = (flags_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign stat = {flags_q, busy};
    assign irq  = |flags_q[B_FAIL:B_INTR];

    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wmask[B_INTR] && !ev_ok) |=> !flags_q[B_INTR]);
    p_zero_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wmask[B_FAIL] && flags_q[B_FAIL]) |=> flags_q[B_FAIL]);
    p_inuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !flags_q[B_INUSE]) |=> flags_q[B_INUSE]);
    p_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fail |=> flags_q[B_FAIL]);

endmodule

// File: rtl/smbh_regfile.sv
module smbh_regfile
    import smbh_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic              load_res,
    input  logic [DATA_W-1:0] res0,
    input  logic [DATA_W-1:0] res1,
    input  logic [DATA_W-1:0] stat,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_stat,
    output logic              rd_stat,
    output logic              start_req,
    output logic              kill_req,
    output logic [KIND_W-1:0] kind,
    output logic              pec,
    output logic [DATA_W-1:0] cmd,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] d0,
    output logic [DATA_W-1:0] d1
);

    logic wr_ctrl, kill_q;
    logic [ADDR_W-1:0] a_stat, a_ctrl, a_cmd, a_addr, a_d0, a_d1;

    assign a_stat = ADDR_W'(OFS_STAT);
    assign a_ctrl = ADDR_W'(OFS_CTRL);
    assign a_cmd  = ADDR_W'(OFS_CMD);
    assign a_addr = ADDR_W'(OFS_ADDR);
    assign a_d0   = ADDR_W'(OFS_D0);
    assign a_d1   = ADDR_W'(OFS_D1);

    assign wr_stat   = reg_wr && (reg_addr == a_stat);
    assign rd_stat   = reg_rd && (reg_addr == a_stat);
    assign wr_ctrl   = reg_wr && (reg_addr == a_ctrl);
    assign start_req = wr_ctrl && reg_wdata[C_START] && !reg_wdata[C_KILL];
    assign kill_req  = wr_ctrl && reg_wdata[C_KILL];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind   <= '0;
            pec    <= 1'b0;
            kill_q <= 1'b0;
        end else if (wr_ctrl) begin
            kill_q <= reg_wdata[C_KILL];
            if (!busy) begin
                kind <= reg_wdata[KIND_LO +: KIND_W];
                pec  <= reg_wdata[C_PEC];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd  <= '0;
            addr <= '0;
        end else if (reg_wr && !busy) begin
            if (reg_addr == a_cmd)  cmd  <= reg_wdata;
            if (reg_addr == a_addr) addr <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d0 <= '0;
            d1 <= '0;
        end else if (load_res && addr[0]) begin
            if (kind == K_BYTE || kind == K_BDATA || kind == K_WORD) d0 <= res0;
            if (kind == K_WORD) d1 <= res1;
        end else if (reg_wr && !busy) begin
            if (reg_addr == a_d0) d0 <= reg_wdata;
            if (reg_addr == a_d1) d1 <= reg_wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (reg_addr == a_stat) rdata = stat;
        if (reg_addr == a_ctrl) begin
            rdata[C_PEC]             = pec;
            rdata[KIND_LO +: KIND_W] = kind;
            rdata[C_KILL]            = kill_q;
        end
        if (reg_addr == a_cmd)  rdata = cmd;
        if (reg_addr == a_addr) rdata = addr;
        if (reg_addr == a_d0)   rdata = d0;
        if (reg_addr == a_d1)   rdata = d1;
    end

    p_hold_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == a_cmd) |=> $stable(cmd));
    p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == a_addr) |=> $stable(addr));

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smbh_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              eng_req,
    output logic              eng_abort,
    output logic [2:0]        eng_kind,
    output logic              eng_pec,
    output logic [DATA_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_cmd,
    output logic [DATA_W-1:0] eng_d0,
    output logic [DATA_W-1:0] eng_d1,
    input  logic              eng_done,
    input  logic              eng_err_dev,
    input  logic              eng_err_bus,
    input  logic [DATA_W-1:0] eng_res0,
    input  logic [DATA_W-1:0] eng_res1,
    input  logic              eng_byte_done,
    input  logic              alert_evt,
    output logic              irq
);

    logic busy, wr_stat, rd_stat, start_req, kill_req;
    logic ev_ok, ev_dev, ev_bus, ev_fail;
    logic [DATA_W-1:0] stat;

    smbh_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .kill_req(kill_req),
        .eng_done(eng_done), .eng_err_dev(eng_err_dev), .eng_err_bus(eng_err_bus),
        .busy(busy), .eng_req(eng_req), .eng_abort(eng_abort),
        .ev_ok(ev_ok), .ev_dev(ev_dev), .ev_bus(ev_bus), .ev_fail(ev_fail)
    );

    smbh_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr_en(wr_stat), .wmask(reg_wdata[DATA_W-1:1]), .rd_en(rd_stat),
        .ev_ok(ev_ok), .ev_dev(ev_dev), .ev_bus(ev_bus), .ev_fail(ev_fail),
        .byte_evt(eng_byte_done), .alert_evt(alert_evt),
        .stat(stat), .irq(irq)
    );

    smbh_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .busy(busy), .load_res(ev_ok), .res0(eng_res0), .res1(eng_res1),
        .stat(stat), .rdata(reg_rdata),
        .wr_stat(wr_stat), .rd_stat(rd_stat),
        .start_req(start_req), .kill_req(kill_req),
        .kind(eng_kind), .pec(eng_pec),
        .cmd(eng_cmd), .addr(eng_addr), .d0(eng_d0), .d1(eng_d1)
    );

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ok |=> (!stat[0] && stat[B_INTR]));
    p_kill_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_req && busy && !eng_abort) |=> eng_abort);

endmodule

// File: tb/smb_host_regs_test.sv
`timescale 1ns/1ps
module smb_host_regs_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0;
    logic [3:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic eng_req, eng_abort, eng_pec, irq;
    logic [2:0] eng_kind;
    logic [7:0] eng_addr, eng_cmd, eng_d0, eng_d1;
    logic eng_done = 0, eng_err_dev = 0, eng_err_bus = 0, eng_byte_done = 0, alert_evt = 0;
    logic [7:0] eng_res0 = 0, eng_res1 = 0;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    smb_host_regs uut (.*);

    // behavioural reference: phase 0 idle, 1 issuing, 2 waiting, 3 aborting
    int ph, nph;
    logic [7:1] mst, setv, clrv;
    logic cw, kr;
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; mst = '0;
        end else begin
            nph = ph; setv = '0;
            cw = reg_wr && reg_addr == 4'd2;
            kr = cw && reg_wdata[1] && (ph == 1 || ph == 2);
            if (ph == 0 && cw && reg_wdata[6] && !reg_wdata[1]) nph = 1;
            if (ph == 1) nph = kr ? 3 : 2;
            if (ph == 2 && kr) nph = 3;
            else if (ph == 2 && eng_done) begin
                nph = 0;
                if (eng_err_dev) setv[2] = 1'b1;
                if (eng_err_bus) setv[3] = 1'b1;
                if (!eng_err_dev && !eng_err_bus) setv[1] = 1'b1;
            end
            if (ph == 3) begin nph = 0; setv[4] = 1'b1; end
            if (eng_byte_done) setv[7] = 1'b1;
            if (alert_evt) setv[5] = 1'b1;
            if (reg_rd && reg_addr == 4'd0 && !mst[6]) setv[6] = 1'b1;
            clrv = (reg_wr && reg_addr == 4'd0) ? reg_wdata[7:1] : '0;
            mst = (mst & ~clrv) | setv;
            ph = nph;
        end
    end

    always @(negedge clk) if (rst_n) begin
        n_cmp += 3;
        if (eng_req !== (ph == 1)) begin n_bad++; $display("FAIL R2 eng_req act=%b exp=%b t=%0t", eng_req, ph == 1, $time); end
        if (eng_abort !== (ph == 3)) begin n_bad++; $display("FAIL R7 eng_abort act=%b exp=%b t=%0t", eng_abort, ph == 3, $time); end
        if (irq !== (|mst[4:1])) begin n_bad++; $display("FAIL R12 irq act=%b exp=%b t=%0t", irq, |mst[4:1], $time); end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] m, input logic [7:0] e, input string tag);
        reg_rd = 1; reg_addr = a; #1;
        chk(tag, reg_rdata & m, e);
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic done(input logic dv, input logic bs, input logic [7:0] r0, input logic [7:0] r1);
        eng_done = 1; eng_err_dev = dv; eng_err_bus = bs; eng_res0 = r0; eng_res1 = r1;
        @(negedge clk); eng_done = 0; eng_err_dev = 0; eng_err_bus = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++; $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        // R1 reset values
        rd(2, 8'hFF, 8'h00, "R1 ctrl"); rd(3, 8'hFF, 8'h00, "R1 cmd");
        rd(4, 8'hFF, 8'h00, "R1 addr"); rd(6, 8'hFF, 8'h00, "R1 data1");
        rd(0, 8'hFF, 8'h00, "R1 status");
        chk("R1 irq", {7'd0, irq}, 8'h00);
        // R10 in-use set after first read
        rd(0, 8'hFF, 8'h40, "R10 inuse set");
        wr(0, 8'h40);
        rd(0, 8'hFF, 8'h00, "R8 R10 inuse cleared");
        wr(0, 8'h40);
        // R3 operands
        wr(4, 8'hA0); wr(3, 8'h11); wr(5, 8'h55); wr(6, 8'h66);
        rd(4, 8'hFF, 8'hA0, "R3 addr"); rd(3, 8'hFF, 8'h11, "R3 cmd");
        rd(9, 8'hFF, 8'h00, "R3 unused offset");
        // R2 start byte-data write with PEC
        wr(2, 8'hC8);
        chk("R2 req", {7'd0, eng_req}, 8'h01);
        chk("R2 kind", {5'd0, eng_kind}, 8'h02);
        chk("R2 pec", {7'd0, eng_pec}, 8'h01);
        chk("R3 eng_addr", eng_addr, 8'hA0); chk("R3 eng_cmd", eng_cmd, 8'h11);
        chk("R3 eng_d0", eng_d0, 8'h55); chk("R3 eng_d1", eng_d1, 8'h66);
        rd(0, 8'h01, 8'h01, "R2 busy");
        // R9 start and operand writes while busy
        wr(2, 8'h4C); wr(3, 8'h99); wr(5, 8'h77);
        rd(2, 8'hFF, 8'h88, "R9 ctrl held"); rd(3, 8'hFF, 8'h11, "R9 cmd held");
        rd(5, 8'hFF, 8'h55, "R9 data0 held");
        wr(0, 8'hFF);
        rd(0, 8'h01, 8'h01, "R8 busy not writable");
        // R4 completion
        done(0, 0, 8'hEE, 8'hEE);
        rd(0, 8'h1F, 8'h02, "R4 complete");
        chk("R12 irq on complete", {7'd0, irq}, 8'h01);
        rd(5, 8'hFF, 8'h55, "R6 write keeps data0");
        wr(0, 8'h02);
        rd(0, 8'h1F, 8'h00, "R8 w1c intr");
        // R6 word read
        wr(4, 8'hA1); wr(2, 8'h4C); @(negedge clk);
        done(0, 0, 8'h34, 8'h12);
        rd(5, 8'hFF, 8'h34, "R6 word low"); rd(6, 8'hFF, 8'h12, "R6 word high");
        wr(0, 8'h02);
        // R6 byte read loads data0 only
        wr(2, 8'h44); @(negedge clk);
        done(0, 0, 8'h5A, 8'hC3);
        rd(5, 8'hFF, 8'h5A, "R6 byte data0"); rd(6, 8'hFF, 8'h12, "R6 byte data1 kept");
        wr(0, 8'h02);
        // R5 errors
        wr(2, 8'h48); @(negedge clk);
        done(1, 0, 8'h00, 8'h00);
        rd(0, 8'h1F, 8'h04, "R5 device error");
        wr(0, 8'h04);
        wr(2, 8'h48); @(negedge clk);
        done(0, 1, 8'h00, 8'h00);
        rd(0, 8'h1F, 8'h08, "R5 bus error");
        wr(0, 8'h08);
        // R7 kill with done racing in the abort cycle
        wr(2, 8'h48); @(negedge clk);
        wr(2, 8'h02);
        chk("R7 abort strobe", {7'd0, eng_abort}, 8'h01);
        done(0, 0, 8'h00, 8'h00);
        rd(0, 8'h1F, 8'h10, "R7 failed only");
        wr(2, 8'h00);
        wr(0, 8'h00);
        rd(0, 8'h1F, 8'h10, "R8 zero write keeps");
        wr(0, 8'h10);
        // R7 start together with kill while idle
        wr(2, 8'h42);
        rd(0, 8'h01, 8'h00, "R7 no launch with kill");
        wr(2, 8'h00);
        // R11 byte-done and alert, R12 no irq
        eng_byte_done = 1; @(negedge clk); eng_byte_done = 0;
        alert_evt = 1; @(negedge clk); alert_evt = 0;
        rd(0, 8'hBF, 8'hA0, "R11 byte and alert");
        chk("R12 no irq", {7'd0, irq}, 8'h00);
        wr(0, 8'hA0);
        rd(0, 8'hBF, 8'h00, "R8 clear high bits");
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule